// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block is a sequential engine that turns a 64-bit input address into a physical output address. It does this by reading 64-bit descriptors from memory, from up to four table levels. A request carries an address and a write flag. The engine first picks one of two table regions by looking at the top bits of the address. It then fetches one descriptor per level over a single-outstanding request/response memory port, and stops at the first leaf it finds (a block or a page). When the walk ends, the engine gives one completion pulse. That pulse carries either the translated address or a fault code together with the address of the descriptor that caused the fault.

Each region has its own table base, granule selector, starting level and disable bit. Region 0 also supplies a count of top address bits. A separate count gives the number of topmost bits that the region test ignores. Only one walk runs at a time, and `req_ready` shows when the engine can accept a new request.

Top module: `pt_walker`

## Requirements
- R1: Region 0 is chosen when every address bit from index 64−`r0_hi_bits` up to 63−`ign_bits` is zero. Otherwise region 1 is chosen. A disabled chosen region gives a translation fault (code 0) and issues no memory read.
- R2: The walk begins at the region's `level` input. The first table address is bits [47:3] of its base, with bits [2:0] forced to zero. Base bits 63:48 have no effect.
- R3: With granule shift g (12, 14 or 16), level L resolves shift s = g + (3−L)(g−3). The index is (address >> s) masked to g−3 bits. The descriptor is read at table + 8·index, with exactly one read issued per level visited.
- R4: A descriptor with bit 0 clear gives a translation fault. So does a level-3 descriptor whose bits [1:0] are 01. The fault address is that descriptor's address.
- R5: Below level 3, type bits [1:0] = 11 continue the walk at the next level and 01 ends it with a block. At level 3, type 11 ends the walk with a page.
- R6: Blocks are legal only at level 1 or 2 with the 4 KB granule, or at level 2 with the 16 KB or 64 KB granule. This gives sizes of 2^30, 2^21, 2^25 and 2^29 bytes. Any other block is a translation fault.
- R7: Output and next-table addresses take descriptor bits [46:n] with all lower bits zero. n is g for tables and pages, and the level shift for blocks. Bits 63:47 are dropped.
- R8: A write request gives a permission fault (code 1) on a leaf with bit 7 set, or on a table descriptor with bit 62 set. Read requests ignore both bits.
- R9: On success, the translated address is the leaf output address plus (input address AND (2^s − 1)) for the final level's shift s.
- R10: An error response to a descriptor read gives a walk external-abort fault (code 2), reporting that descriptor's address.
- R11: Each accepted request completes with exactly one `done` pulse, with the fault code 0 on success. Requests are accepted only while `req_ready` is high, and requests offered during a walk are ignored.
- R12: Granule selector 0/1/2 means 4 KB/16 KB/64 KB. Selector 3 gives a translation fault with no memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | Input address |
| req_write | input | 1 | Request is a write |
| req_ready | output | 1 | Engine idle, request may be offered |
| ign_bits | input | 7 | Topmost address bits ignored by region choice |
| r0_hi_bits | input | 7 | Top-bit count tested for region choice |
| r0_base | input | 64 | Region 0 first table address |
| r0_gran | input | 2 | Region 0 granule selector |
| r0_level | input | 2 | Region 0 starting level |
| r0_off | input | 1 | Region 0 disabled |
| r1_base | input | 64 | Region 1 first table address |
| r1_gran | input | 2 | Region 1 granule selector |
| r1_level | input | 2 | Region 1 starting level |
| r1_off | input | 1 | Region 1 disabled |
| mem_req_valid | output | 1 | Descriptor read request (one cycle) |
| mem_req_addr | output | 64 | Descriptor address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 64 | Descriptor returned |
| mem_rsp_err | input | 1 | Read response error |
| done | output | 1 | Walk completion pulse |
| done_ok | output | 1 | Walk succeeded |
| done_fault | output | 2 | Fault code: 0 translation, 1 permission, 2 external abort |
| done_fault_addr | output | 64 | Faulting descriptor address (0 if no read was made) |
| done_pa | output | 64 | Translated address |

## Verification
If the level counter or table pointer goes wrong, the next read appears at the wrong address. Because the bench only answers for addresses it has written, the walk then ends in an external abort on the very next descriptor. A wrong shift or mask shows up one cycle after the final response, as a translated address whose offset bits or frame bits do not match the bench's arithmetic. A stuck state machine shows up as a missing or duplicated `done` pulse, or as a wrong count of memory reads for the walk.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  input  logic        req_write,
  output logic        req_ready,
  input  logic [6:0]  ign_bits,
  input  logic [6:0]  r0_hi_bits,
  input  logic [63:0] r0_base,
  input  logic [1:0]  r0_gran,
  input  logic [1:0]  r0_level,
  input  logic        r0_off,
  input  logic [63:0] r1_base,
  input  logic [1:0]  r1_gran,
  input  logic [1:0]  r1_level,
  input  logic        r1_off,
  output logic        mem_req_valid,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        done,
  output logic        done_ok,
  output logic [1:0]  done_fault,
  output logic [63:0] done_fault_addr,
  output logic [63:0] done_pa
);
  localparam logic [63:0] OA_MASK = 64'h0000_7FFF_FFFF_FFFF;
  localparam logic [1:0] F_XLAT = 2'd0, F_PERM = 2'd1, F_ABORT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT} st_t;
  st_t st;

  logic [63:0] va, base;
  logic        wr;
  logic [1:0]  lvl;
  logic [4:0]  g;

  logic hi_zero;
  always_comb begin
    hi_zero = 1'b1;
    for (int i = 0; i < 64; i++)
      if (i >= 64 - int'(r0_hi_bits) && i <= 63 - int'(ign_bits) && req_addr[i])
        hi_zero = 1'b0;
  end

  logic [63:0] s_base;
  logic [1:0]  s_gran, s_lvl;
  logic        s_off;
  assign s_base = hi_zero ? r0_base  : r1_base;
  assign s_gran = hi_zero ? r0_gran  : r1_gran;
  assign s_lvl  = hi_zero ? r0_level : r1_level;
  assign s_off  = hi_zero ? r0_off   : r1_off;

  logic [4:0] s_g;
  always_comb
    case (s_gran)
      2'd0:    s_g = 5'd12;
      2'd1:    s_g = 5'd14;
      2'd2:    s_g = 5'd16;
      default: s_g = 5'd0;
    endcase

  logic [5:0]  sh;
  logic [63:0] idx, daddr, lvl_mask, g_mask, d;
  assign sh       = 6'(g) + 6'(2'd3 - lvl) * 6'(g - 5'd3);
  assign idx      = (va >> sh) & ((64'd1 << (g - 5'd3)) - 64'd1);
  assign daddr    = base + (idx << 3);
  assign lvl_mask = (64'd1 << sh) - 64'd1;
  assign g_mask   = (64'd1 << g) - 64'd1;
  assign d        = mem_rsp_data;

  logic is_tab, is_blk, blk_ok;
  assign is_tab = (lvl != 2'd3) && (d[1:0] == 2'b11);
  assign is_blk = (lvl != 2'd3) && (d[1:0] == 2'b01);
  assign blk_ok = (g == 5'd12) ? (lvl == 2'd1 || lvl == 2'd2) : (lvl == 2'd2);

  logic        fin, f_ok, go_next;
  logic [1:0]  f_code;
  always_comb begin
    fin = 1'b1; f_ok = 1'b0; f_code = F_XLAT; go_next = 1'b0;
    if (mem_rsp_err)                                 f_code = F_ABORT;
    else if (!d[0] || (lvl == 2'd3 && d[1:0] == 2'b01)) f_code = F_XLAT;
    else if (is_tab) begin
      if (wr && d[62]) f_code = F_PERM;
      else begin fin = 1'b0; go_next = 1'b1; end
    end
    else if (is_blk && !blk_ok)                      f_code = F_XLAT;
    else if (wr && d[7])                             f_code = F_PERM;
    else                                             f_ok = 1'b1;
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_FETCH);
  assign mem_req_addr  = daddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; va <= '0; base <= '0; wr <= 1'b0; lvl <= '0; g <= 5'd12;
      done <= 1'b0; done_ok <= 1'b0; done_fault <= '0;
      done_fault_addr <= '0; done_pa <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va   <= req_addr;
          wr   <= req_write;
          base <= {16'b0, s_base[47:3], 3'b000};
          lvl  <= s_lvl;
          g    <= s_g;
          if (s_off || s_gran == 2'd3) begin
            done <= 1'b1; done_ok <= 1'b0; done_fault <= F_XLAT;
            done_fault_addr <= '0; done_pa <= '0;
          end else st <= S_FETCH;
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (go_next) begin
            base <= d & OA_MASK & ~g_mask;
            lvl  <= lvl + 2'd1;
            st   <= S_FETCH;
          end else if (fin) begin
            st <= S_IDLE;
            done <= 1'b1; done_ok <= f_ok;
            done_fault <= f_ok ? F_XLAT : f_code;
            done_fault_addr <= f_ok ? 64'd0 : daddr;
            done_pa <= f_ok ? ((d & OA_MASK & ~lvl_mask) + (va & lvl_mask)) : 64'd0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic [63:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        mem_rsp_err,
  input logic        done,
  input logic        done_ok,
  input logic [1:0]  done_fault
);
  p_read_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  p_read_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000);
  p_busy_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  p_ok_code_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_ok) |-> done_fault == 2'd0);
  p_abort_after_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok && done_fault == 2'd2) |-> $past(mem_rsp_valid && mem_rsp_err));
  p_code_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_ok) |-> done_fault != 2'd3);
endmodule

bind pt_walker pt_walker_chk chk_i (.*);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic req_ready;
  logic [6:0] ign_bits = 7'd0, r0_hi_bits = 7'd16;
  logic [63:0] r0_base = '0, r1_base = '0;
  logic [1:0] r0_gran = '0, r0_level = '0, r1_gran = '0, r1_level = '0;
  logic r0_off = 1'b0, r1_off = 1'b0;
  logic mem_req_valid;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic done, done_ok;
  logic [1:0] done_fault;
  logic [63:0] done_fault_addr, done_pa;

  always #10 clk = ~clk;

  pt_walker dut_i (.*);

  int nchk = 0, nfail = 0, nreq = 0, ndone = 0;
  logic [63:0] mem [logic [63:0]];
  logic r_ok; logic [1:0] r_code; logic [63:0] r_fa, r_pa;

  initial begin
    logic pend; logic [63:0] pa;
    pend = 1'b0; pa = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        if (mem.exists(pa)) begin mem_rsp_data = mem[pa]; mem_rsp_err = 1'b0; end
        else begin mem_rsp_data = '0; mem_rsp_err = 1'b1; end
        pend = 1'b0;
      end
      if (mem_req_valid) begin pa = mem_req_addr; pend = 1'b1; nreq++; end
    end
  end

  initial forever begin @(negedge clk); if (done) ndone++; end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input bit c, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int gbits(int gs);
    case (gs) 0: return 12; 1: return 14; default: return 16; endcase
  endfunction

  function automatic int lsh(int gs, int l);
    case (gs)
      0: case (l) 0: return 39; 1: return 30; 2: return 21; default: return 12; endcase
      1: case (l) 0: return 47; 1: return 36; 2: return 25; default: return 14; endcase
      default: case (l) 0: return 55; 1: return 42; 2: return 29; default: return 16; endcase
    endcase
  endfunction

  function automatic logic [63:0] ix(logic [63:0] va, int gs, int l);
    return (va >> lsh(gs, l)) & ((64'd1 << (gbits(gs) - 3)) - 1);
  endfunction

  function automatic logic [63:0] tbl(int l);
    return 64'h0000_0040_0000_0000 + 64'(l) * 64'h0100_0000;
  endfunction

  function automatic logic [63:0] daddr(logic [63:0] va, int gs, int l);
    return tbl(l) + ix(va, gs, l) * 8;
  endfunction

  task automatic build(input int gs, input int st, input int leaf, input logic [63:0] leafd,
                       input logic [63:0] va, input logic [63:0] tabx);
    mem.delete();
    for (int l = st; l < leaf; l++)
      mem[daddr(va, gs, l)] = tbl(l + 1) | 64'h0080_0000_0000_0400 | tabx | 64'd3;
    mem[daddr(va, gs, leaf)] = leafd;
    r0_gran = 2'(gs); r0_level = 2'(st); r0_base = tbl(st); r0_off = 1'b0;
  endtask

  task automatic run(input logic [63:0] va, input logic w);
    bit got;
    got = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = w;
    for (int k = 0; k < 400 && !got; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) begin
        got = 1'b1; r_ok = done_ok; r_code = done_fault; r_fa = done_fault_addr; r_pa = done_pa;
      end
    end
    if (!got) begin r_ok = 1'b0; r_code = 2'd3; r_fa = '0; r_pa = '0; end
    chk(got, "R11 done pulse", 64'(got), 64'd1);
  endtask

  localparam logic [63:0] FPG = 64'h0000_6ABC_0000_0000;
  localparam logic [63:0] FBK = 64'h0000_0055_4000_0000;

  initial begin
    int n0, d0;
    logic [63:0] va, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R11 done low after reset", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R3 no read after reset", 64'(mem_req_valid), 64'd0);

    for (int gs = 0; gs < 3; gs++)
      for (int st = 0; st < 3; st++) begin
        va = 64'h0000_4A5B_6C7D_8E9F ^ (64'(gs) * 64'h0000_1111_0000_1357) ^ (64'(st) * 64'h0000_0002_4000_0A0C);
        build(gs, st, 3, FPG | 64'h0010_0000_0000_0400 | 64'd3, va, 64'd0);
        if (st == 2) r0_base = tbl(st) | 64'hFFFF_0000_0000_0005;
        n0 = nreq;
        run(va, 1'b0);
        e = FPG + (va & ((64'd1 << gbits(gs)) - 1));
        chk(r_ok, "R5 page walk ok", 64'(r_ok), 64'd1);
        chk(r_pa == e, "R9 R7 page translated address", r_pa, e);
        chk(nreq - n0 == 4 - st, "R2 R3 reads per walk", 64'(nreq - n0), 64'(4 - st));
      end

    for (int b = 0; b < 4; b++) begin
      int gs, l;
      gs = (b < 2) ? 0 : b - 1;
      l  = (b == 0) ? 1 : 2;
      va = 64'h0000_3123_4567_89AB ^ (64'(b) * 64'h0000_0000_1234_5678);
      build(gs, l - 1, l, FBK | (64'd1 << gbits(gs)) | 64'h0008_0000_0000_0000 | 64'd1, va, 64'd0);
      run(va, 1'b1);
      e = FBK + (va & ((64'd1 << lsh(gs, l)) - 1));
      chk(r_ok, "R6 legal block ok", 64'(r_ok), 64'd1);
      chk(r_pa == e, "R6 R7 R9 block translated address", r_pa, e);
    end

    for (int b = 0; b < 3; b++) begin
      int gs, l;
      gs = b; l = (b == 0) ? 0 : 1;
      va = 64'h0000_2222_3333_4444;
      build(gs, l, l, FBK | 64'd1, va, 64'd0);
      run(va, 1'b0);
      chk(!r_ok && r_code == 2'd0, "R6 illegal block code", 64'(r_code), 64'd0);
      chk(r_fa == daddr(va, gs, l), "R6 illegal block fault addr", r_fa, daddr(va, gs, l));
    end

    va = 64'h0000_0000_1234_5678;
    build(0, 3, 3, FPG | 64'd1, va, 64'd0);
    run(va, 1'b0);
    chk(!r_ok && r_code == 2'd0, "R4 reserved level-3 type", 64'(r_code), 64'd0);
    chk(r_fa == daddr(va, 0, 3), "R4 reserved fault addr", r_fa, daddr(va, 0, 3));
    build(0, 1, 2, FBK | 64'd2, va, 64'd0);
    run(va, 1'b0);
    chk(!r_ok && r_code == 2'd0, "R4 invalid descriptor", 64'(r_code), 64'd0);
    chk(r_fa == daddr(va, 0, 2), "R4 invalid fault addr", r_fa, daddr(va, 0, 2));

    build(0, 2, 3, FPG | 64'h80 | 64'd3, va, 64'd0);
    run(va, 1'b1);
    chk(!r_ok && r_code == 2'd1, "R8 page bit7 write", 64'(r_code), 64'd1);
    chk(r_fa == daddr(va, 0, 3), "R8 page perm fault addr", r_fa, daddr(va, 0, 3));
    run(va, 1'b0);
    chk(r_ok && r_pa == FPG + (va & 64'hFFF), "R8 page bit7 read ok", r_pa, FPG + (va & 64'hFFF));
    build(1, 1, 3, FPG | 64'd3, va, 64'h4000_0000_0000_0000);
    run(va, 1'b1);
    chk(!r_ok && r_code == 2'd1, "R8 table bit62 write", 64'(r_code), 64'd1);
    chk(r_fa == daddr(va, 1, 1), "R8 table perm fault addr", r_fa, daddr(va, 1, 1));
    run(va, 1'b0);
    chk(r_ok && r_pa == FPG + (va & 64'h3FFF), "R8 table bit62 read ok", r_pa, FPG + (va & 64'h3FFF));
    build(2, 2, 2, FBK | 64'h80 | 64'd1, va, 64'd0);
    run(va, 1'b1);
    chk(!r_ok && r_code == 2'd1, "R8 block bit7 write", 64'(r_code), 64'd1);

    build(0, 1, 3, FPG | 64'd3, va, 64'd0);
    mem.delete(daddr(va, 0, 2));
    run(va, 1'b0);
    chk(!r_ok && r_code == 2'd2, "R10 abort code", 64'(r_code), 64'd2);
    chk(r_fa == daddr(va, 0, 2), "R10 abort fault addr", r_fa, daddr(va, 0, 2));

    build(0, 3, 3, FPG | 64'd3, va, 64'd0);
    r0_off = 1'b1; n0 = nreq;
    run(va, 1'b0);
    chk(!r_ok && r_code == 2'd0, "R1 disabled region fault", 64'(r_code), 64'd0);
    chk(nreq == n0, "R1 disabled region no read", 64'(nreq - n0), 64'd0);
    r0_off = 1'b0; r0_gran = 2'd3; n0 = nreq;
    run(va, 1'b0);
    chk(!r_ok && r_code == 2'd0, "R12 granule 3 fault", 64'(r_code), 64'd0);
    chk(nreq == n0, "R12 granule 3 no read", 64'(nreq - n0), 64'd0);
    r0_gran = 2'd0;

    ign_bits = 7'd8;
    mem.delete();
    r1_base = 64'h0000_0077_0000_0000; r1_gran = 2'd0; r1_level = 2'd3; r1_off = 1'b0;
    va = 64'h1000_0000_0000_5ABC;
    mem[daddr(va, 0, 3)] = FPG | 64'd3;
    r0_base = tbl(3); r0_level = 2'd3;
    run(va, 1'b0);
    chk(r_ok && r_pa == FPG + 64'hABC, "R1 ignored top bits pick region 0", r_pa, FPG + 64'hABC);
    va = 64'h0004_0000_0000_5ABC;
    mem[r1_base + ix(va, 0, 3) * 8] = FBK | 64'd3;
    run(va, 1'b0);
    chk(r_ok && r_pa == FBK + 64'hABC, "R1 nonzero bit picks region 1", r_pa, FBK + 64'hABC);
    r1_off = 1'b1;
    run(va, 1'b0);
    chk(!r_ok && r_code == 2'd0, "R1 disabled region 1", 64'(r_code), 64'd0);
    ign_bits = 7'd0;

    va = 64'h0000_0000_0000_1234;
    build(0, 3, 3, FPG | 64'd3, va, 64'd0);
    d0 = ndone; n0 = nreq;
    @(negedge clk);
    req_valid = 1'b1; req_addr = va; req_write = 1'b0;
    @(negedge clk);
    req_addr = 64'h0000_0000_0999_9000;
    chk(req_ready == 1'b0, "R11 not ready while busy", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) begin r_ok = done_ok; r_pa = done_pa; end
    end
    chk(ndone - d0 == 1, "R11 single completion", 64'(ndone - d0), 64'd1);
    chk(nreq - n0 == 1, "R11 busy request ignored", 64'(nreq - n0), 64'd1);
    chk(r_ok && r_pa == FPG + 64'h234, "R11 first request result", r_pa, FPG + 64'h234);

    summary();
    $finish;
  end
endmodule